// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Mapped Registers

The block gathers up to 32 interrupt sources into one request line for a processor. Each source is fixed at elaboration time as edge-sensitive or level-sensitive. Captured activity sits in a status register. That register is masked by an enable register to form the pending set. The block reports the lowest-numbered pending source as a vector number.

Software reaches eight 32-bit registers through a simple synchronous port. The port has a write strobe, a byte address, write data and a combinational read-data return. Three write-only locations make single-write operations possible: acknowledging sources, setting enable bits and clearing enable bits. A two-bit master enable has two separate bits. One lets hardware activity into the status register. The other lets the request out to the processor.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The word index is byte address bits [5:2]. Only addresses with bits [1:0] equal to zero select a register. Index 0 is status, 1 is pending, 2 is enable, 3 is acknowledge, 4 is enable-set, 5 is enable-clear, 6 is vector and 7 is master enable. Reads of indices 3, 4 and 5, of indices 8 to 15, and of misaligned addresses all return zero.
- R2: Pending always equals status AND enable, and it reads back at index 1.
- R3: The vector register reads the index of the lowest-numbered pending bit. With nothing pending it reads 32'hFFFF_FFFF.
- R4: irq_o is high only when master-enable bit 0 is 1, master-enable bit 1 is 1 and at least one pending bit is set. It follows a register write in the same cycle as the register changes.
- R5: A write to index 3 clears every status bit whose written bit is 1 and leaves the other bits alone.
- R6: A write to index 4 ORs the data into enable. A write to index 5 clears every enable bit whose written bit is 1.
- R7: A write to index 0, 2 or 7 stores the data. Master enable keeps bits [1:0]. Writes to index 1, index 6, undefined indices and misaligned addresses change nothing.
- R8: While master-enable bit 1 is 0, input activity does not change status.
- R9: An edge source (its EDGE_MASK bit is 1) sets its status bit at the clock edge after its input rises while capture is on. The bit stays set after the input falls, until it is acknowledged. A rise in the same cycle as its acknowledge wins.
- R10: While capture is on, a level source (its EDGE_MASK bit is 0) loads its input into its status bit at each clock edge. This overrides a software write to status in that cycle.
- R11: Reset clears status, enable and master enable, so irq_o is low and the vector reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_in | input | 32 | Interrupt source inputs, synchronous to clk |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets these mistakes:
- A rising edge that arrives in the same cycle as its acknowledge. A design that lets the acknowledge win silently loses that interrupt.
- A level source whose status is written by software while capture is on. A design that honours the write leaves a stale request that the input no longer asserts.
- The two master-enable bits. A mixed-up design either fires the output with capture off or latches activity while gated.
- The vector with no bit pending, and with only bit 31 pending, which catches a scan that stops one short or returns zero in place of all ones.
- Writes to pending, to vector and to unmapped locations. A loose decoder would corrupt enable or status there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned NUM_REGS = 8;

   typedef enum logic [2:0] {
      IX_STATUS  = 3'd0,
      IX_PENDING = 3'd1,
      IX_ENABLE  = 3'd2,
      IX_ACK     = 3'd3,
      IX_ENSET   = 3'd4,
      IX_ENCLR   = 3'd5,
      IX_VECTOR  = 3'd6,
      IX_MASTER  = 3'd7
   } reg_ix_e;

   localparam int unsigned MASTER_OUT_BIT = 0;
   localparam int unsigned MASTER_CAP_BIT = 1;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
   parameter bit IS_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic cap_i,
   input  logic base_i,
   output logic stat_o
);
   logic stat_q;
   logic stat_d;

   generate
      if (IS_EDGE) begin : g_edge
         logic src_q;
         logic rise;

         always_ff @(posedge clk) begin
            if (!rst_n) src_q <= 1'b0;
            else        src_q <= src_i;
         end

         assign rise   = src_i & ~src_q;
         assign stat_d = base_i | (cap_i & rise);

         // R9: latched bit survives until software acts on it
         p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q && base_i) |=> stat_q);
         // R9: a captured rise always lands, even against an acknowledge
         p_edge_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_i && src_i && !src_q) |=> stat_q);
      end else begin : g_level
         assign stat_d = cap_i ? src_i : base_i;

         // R10: level sources track the input while capture is on
         p_level_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cap_i |=> (stat_q == $past(src_i)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [IW-1:0] idx_o,
   output logic          valid_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("irqc_first_set: N must be at least 1");
      end
      if ((1 << IW) < N) begin : g_bad_iw
         $error("irqc_first_set: IW too narrow for N");
      end
   endgenerate

   always_comb begin
      idx_o   = '0;
      valid_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o   = IW'(i);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 6,
   parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   input  logic [NSRC-1:0] irq_in,
   output logic            irq_o
);
   localparam int unsigned IXW = AW - 2;
   localparam int unsigned VW  = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
         $error("irq_vector_ctrl: NSRC must lie in 1..DW");
      end
      if (AW < 5) begin : g_bad_aw
         $error("irq_vector_ctrl: AW must cover eight word registers");
      end
      if (DW < 2) begin : g_bad_dw
         $error("irq_vector_ctrl: DW must hold the master-enable bits");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [IXW-1:0] ix;
   logic           aligned;
   logic           mapped;
   logic [2:0]     ix3;

   assign ix      = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign mapped  = aligned && (ix < IXW'(NUM_REGS));
   assign ix3     = ix[2:0];

   logic wr_status, wr_enable, wr_ack, wr_enset, wr_enclr, wr_master;

   always_comb begin
      wr_status = 1'b0;
      wr_enable = 1'b0;
      wr_ack    = 1'b0;
      wr_enset  = 1'b0;
      wr_enclr  = 1'b0;
      wr_master = 1'b0;
      if (wr_en && mapped) begin
         unique case (reg_ix_e'(ix3))
            IX_STATUS: wr_status = 1'b1;
            IX_ENABLE: wr_enable = 1'b1;
            IX_ACK:    wr_ack    = 1'b1;
            IX_ENSET:  wr_enset  = 1'b1;
            IX_ENCLR:  wr_enclr  = 1'b1;
            IX_MASTER: wr_master = 1'b1;
            default:   ;
         endcase
      end
   end

   logic [NSRC-1:0] wd_src;
   assign wd_src = wdata[NSRC-1:0];

   // ---------------- master enable ----------------
   logic [1:0] master_q;
   logic       cap_on;
   logic       out_on;

   always_ff @(posedge clk) begin
      if (!rst_n)         master_q <= 2'b00;
      else if (wr_master) master_q <= wdata[1:0];
   end

   assign cap_on = master_q[MASTER_CAP_BIT];
   assign out_on = master_q[MASTER_OUT_BIT];

   // ---------------- enable register ----------------
   logic [NSRC-1:0] enable_q;
   logic [NSRC-1:0] enable_d;

   always_comb begin
      enable_d = enable_q;
      if (wr_enable) enable_d = wd_src;
      if (wr_enset)  enable_d = enable_q | wd_src;
      if (wr_enclr)  enable_d = enable_q & ~wd_src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) enable_q <= '0;
      else        enable_q <= enable_d;
   end

   // ---------------- status register ----------------
   logic [NSRC-1:0] status;
   logic [NSRC-1:0] status_base;

   always_comb begin
      status_base = status;
      if (wr_status) status_base = wd_src;
      if (wr_ack)    status_base = status & ~wd_src;
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         irqc_src_cell #(
            .IS_EDGE (EDGE_MASK[s])
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (irq_in[s]),
            .cap_i  (cap_on),
            .base_i (status_base[s]),
            .stat_o (status[s])
         );
      end
   endgenerate

   // ---------------- pending, vector, request ----------------
   logic [NSRC-1:0] pending;
   logic [VW-1:0]   vec_idx;
   logic            vec_ok;

   assign pending = status & enable_q;

   irqc_first_set #(
      .N  (NSRC),
      .IW (VW)
   ) u_first (
      .req_i   (pending),
      .idx_o   (vec_idx),
      .valid_o (vec_ok)
   );

   assign irq_o = out_on & cap_on & (|pending);

   // ---------------- read path ----------------
   always_comb begin
      rdata = '0;
      if (mapped) begin
         unique case (reg_ix_e'(ix3))
            IX_STATUS:  rdata = DW'(status);
            IX_PENDING: rdata = DW'(pending);
            IX_ENABLE:  rdata = DW'(enable_q);
            IX_VECTOR:  rdata = vec_ok ? DW'(vec_idx) : '1;
            IX_MASTER:  rdata = DW'(master_q);
            default:    rdata = '0;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R5: acknowledged bits are gone when hardware cannot re-set them
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !cap_on) |=> ((status & $past(wd_src)) == '0));

   // R6: set alias leaves every written one in enable
   p_enset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enset |=> ((enable_q & $past(wd_src)) == $past(wd_src)));

   // R6: clear alias removes every written one from enable
   p_enclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enclr |=> ((enable_q & $past(wd_src)) == '0));

   // R8: with capture off and no software access, status holds
   p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_on && !wr_status && !wr_ack) |=> $stable(status));

   // R3: the reported vector is the lowest pending bit
   p_vec_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ok |-> (pending[vec_idx] &&
                  ((pending & ((NSRC'(1) << vec_idx) - NSRC'(1))) == '0)));

   // R3: no valid vector means nothing pending
   p_vec_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_ok |-> (pending == '0));

   // R4: clearing the output enable drops the request
   p_out_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_master && !wdata[MASTER_OUT_BIT]) |=> !irq_o);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   localparam logic [31:0] EDGES = 32'h0000_00F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] irq_in = '0;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_vector_ctrl #(
      .NSRC (32), .DW (32), .AW (6), .EDGE_MASK (EDGES)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wdata (wdata), .rdata (rdata), .irq_in (irq_in), .irq_o (irq_o)
   );

   typedef struct packed {
      logic [31:0] src;
      logic        we;
      logic [5:0]  wa;
      logic [31:0] wd;
      logic [5:0]  ra;
      logic [31:0] exp_rd;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t TBL [NV] = '{
      '{32'h1,  1'b0, 6'h00, 32'h0,        6'h00, 32'h0,         1'b0, 8'd8 },  // R8 gated
      '{32'h1,  1'b1, 6'h1C, 32'h3,        6'h1C, 32'h3,         1'b0, 8'd7 },  // R7 master
      '{32'h1,  1'b0, 6'h00, 32'h0,        6'h00, 32'h1,         1'b0, 8'd10},  // R10 level
      '{32'h1,  1'b1, 6'h10, 32'h11,       6'h08, 32'h11,        1'b1, 8'd6 },  // R6 set
      '{32'h1,  1'b0, 6'h00, 32'h0,        6'h04, 32'h1,         1'b1, 8'd2 },  // R2
      '{32'h1,  1'b0, 6'h00, 32'h0,        6'h18, 32'h0,         1'b1, 8'd3 },  // R3
      '{32'h11, 1'b0, 6'h00, 32'h0,        6'h00, 32'h11,        1'b1, 8'd9 },  // R9 rise
      '{32'h0,  1'b0, 6'h00, 32'h0,        6'h00, 32'h10,        1'b1, 8'd9 },  // R9 hold
      '{32'h0,  1'b0, 6'h00, 32'h0,        6'h18, 32'h4,         1'b1, 8'd3 },  // R3
      '{32'h0,  1'b1, 6'h1C, 32'h2,        6'h04, 32'h10,        1'b0, 8'd4 },  // R4 out off
      '{32'h0,  1'b1, 6'h1C, 32'h3,        6'h00, 32'h10,        1'b1, 8'd4 },  // R4 out on
      '{32'h0,  1'b1, 6'h0C, 32'h10,       6'h00, 32'h0,         1'b0, 8'd5 },  // R5 ack
      '{32'h0,  1'b0, 6'h00, 32'h0,        6'h18, 32'hFFFF_FFFF, 1'b0, 8'd3 },  // R3 none
      '{32'h0,  1'b0, 6'h00, 32'h0,        6'h0C, 32'h0,         1'b0, 8'd1 },  // R1 alias
      '{32'h0,  1'b1, 6'h08, 32'hFFFF_FFFF,6'h08, 32'hFFFF_FFFF, 1'b0, 8'd7 },  // R7 enable
      '{32'h0,  1'b1, 6'h14, 32'hFFFF_0000,6'h08, 32'h0000_FFFF, 1'b0, 8'd6 },  // R6 clear
      '{32'h0,  1'b1, 6'h00, 32'hA0,       6'h00, 32'hA0,        1'b1, 8'd7 },  // R7 status
      '{32'h0,  1'b0, 6'h00, 32'h0,        6'h18, 32'h5,         1'b1, 8'd3 },  // R3
      '{32'h20, 1'b1, 6'h0C, 32'h20,       6'h00, 32'hA0,        1'b1, 8'd9 },  // R9 rise beats ack
      '{32'h20, 1'b1, 6'h0C, 32'hA0,       6'h00, 32'h0,         1'b0, 8'd5 },  // R5
      '{32'h0,  1'b1, 6'h1C, 32'h1,        6'h1C, 32'h1,         1'b0, 8'd4 },  // R4
      '{32'h40, 1'b0, 6'h00, 32'h0,        6'h00, 32'h0,         1'b0, 8'd8 },  // R8 edge gated
      '{32'h40, 1'b1, 6'h00, 32'h8000_0000,6'h00, 32'h8000_0000, 1'b0, 8'd7 },  // R7
      '{32'h40, 1'b1, 6'h10, 32'h8000_0000,6'h18, 32'h1F,        1'b0, 8'd4 },  // R4 cap off
      '{32'h40, 1'b1, 6'h1C, 32'h3,        6'h18, 32'h1F,        1'b1, 8'd3 },  // R3 top bit
      '{32'h40, 1'b0, 6'h00, 32'h0,        6'h00, 32'h0,         1'b0, 8'd10},  // R10 clears
      '{32'h0,  1'b1, 6'h20, 32'hFFFF_FFFF,6'h20, 32'h0,         1'b0, 8'd1 },  // R1 undefined
      '{32'h0,  1'b1, 6'h09, 32'h0,        6'h09, 32'h0,         1'b0, 8'd1 },  // R1 misaligned
      '{32'h0,  1'b1, 6'h04, 32'hFFFF_FFFF,6'h08, 32'h8000_FFFF, 1'b0, 8'd7 }   // R7 pending write ignored
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      wr_en = 1'b0;
      addr  = a;
      #1;
      check(tag, rdata, exp);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      rd(6'h00, 32'h0, "R11 status");
      rd(6'h08, 32'h0, "R11 enable");
      rd(6'h1C, 32'h0, "R11 master");
      rd(6'h04, 32'h0, "R11 pending");
      rd(6'h18, 32'hFFFF_FFFF, "R11 vector");
      check("R11 irq", {31'd0, irq_o}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         irq_in = TBL[k].src;
         wr_en  = TBL[k].we;
         addr   = TBL[k].wa;
         wdata  = TBL[k].wd;
         @(negedge clk);
         wr_en  = 1'b0;
         addr   = TBL[k].ra;
         #1;
         check($sformatf("R%0d row%0d rdata", TBL[k].req, k), rdata, TBL[k].exp_rd);
         check($sformatf("R%0d row%0d irq", TBL[k].req, k), {31'd0, irq_o}, {31'd0, TBL[k].exp_irq});
      end

      // R1: write-only aliases read zero after enable is nonzero
      rd(6'h10, 32'h0, "R1 set alias");
      rd(6'h14, 32'h0, "R1 clear alias");

      // R11: mid-run reset returns everything to zero
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(6'h08, 32'h0, "R11 enable after reset");
      rd(6'h1C, 32'h0, "R11 master after reset");
      check("R11 irq after reset", {31'd0, irq_o}, 32'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule